// File: doc/BRIEF.md
# Serial Trim Code Register with Nonvolatile Copy

This block is the digital part of a display common-voltage trimmer. It sits on a two-wire serial bus as a slave with the 7-bit address 1001111. It holds a 7-bit code that sets one of 128 steps of an external current-sink DAC. A working register drives the DAC code pin. A second register models the nonvolatile copy, and a programmable cycle count stands in for the slow cell write.

A bus write is accepted only while the write-enable input is high. It updates the working code at once and then starts a timed commit into the nonvolatile copy. During the commit the busy flag is high and new addressing is refused. When write-enable falls, or when the block comes out of reset, the working code is restored from the nonvolatile copy. SCL and SDA are synchronised and filtered so that short spikes are rejected. SDA is driven through a separate open-drain enable.

Top module: `vcom_trim_i2c`

## Requirements
- R1: During and after reset, before any bus traffic, code_o equals INIT_CODE, busy_o is 0 and sda_oe_o is 0.
- R2: The address bytes 0x9E (write) and 0x9F (read) are acknowledged. Any other address gets no acknowledge, and sda_oe_o stays 0 until the next START.
- R3: A write of START, 0x9E, register byte 0x00 and one data byte with wp_i high sets code_o to the low 7 bits of the data byte. Bit 7 of the data byte is ignored. Every byte is acknowledged.
- R4: With wp_i low, the same write is still acknowledged, but code_o does not change and no commit starts: busy_o stays 0.
- R5: A high-to-low transition of wp_i loads code_o from the nonvolatile copy, which holds the last completed commit, even while a later commit is still running.
- R6: Each accepted write holds busy_o high for exactly COMMIT_CYC clock cycles. At the end, the nonvolatile copy holds the written code.
- R7: While busy_o is high, an address byte, read or write, gets no acknowledge.
- R8: A read (START, 0x9F) returns one byte with code_o in bits 6:0 and 0 in bit 7, MSB first. After the master's NACK and a STOP, sda_oe_o is 0.
- R9: If the register byte is not 0x00, the data byte is acknowledged and ignored. Bytes after the data byte are acknowledged and ignored.
- R10: Pulses on SCL or SDA shorter than FILT_LEN clock cycles have no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wp_i | input | 1 | Write enable. Low protects; a falling edge reloads the code |
| code_o | output | CODE_W | Trim code to the DAC, unsigned and monotonic |
| busy_o | output | 1 | Nonvolatile commit in progress |

## Verification
Every bus edge reaches the state machine about FILT_LEN+3 cycles late. The bench therefore spaces SCL edges 32 cycles apart and samples SDA in the middle of the SCL-high window, long after any slave change has settled. The new code appears on code_o one cycle after the SCL fall that ends the data byte. Write-enable reloads land within four cycles of the pin falling. The bench reads code_o only after STOP, or ten cycles after moving wp_i. busy_o is counted cycle by cycle at the falling clock edge and compared with COMMIT_CYC after it drops.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_DATA,
    ST_EXTRA,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_glitch_filt.sv
module i2c_glitch_filt #(
  parameter int FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], in_i};
      if (sync_q[1] == out_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_o <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nv_shadow.sv
module nv_shadow #(
  parameter int              CODE_W     = 7,
  parameter int              COMMIT_CYC = 12_500_000,
  parameter logic [CODE_W-1:0] INIT_CODE = 7'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] shadow_o,
  output logic              busy_o
);
  localparam int TW = $clog2(COMMIT_CYC + 1);

  logic [TW-1:0]     tmr_q;
  logic [CODE_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q    <= '0;
      pend_q   <= INIT_CODE;
      shadow_o <= INIT_CODE;
      busy_o   <= 1'b0;
    end else if (start_i && !busy_o) begin
      pend_q <= data_i;
      tmr_q  <= TW'(COMMIT_CYC - 1);
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (tmr_q == '0) begin
        busy_o   <= 1'b0;
        shadow_o <= pend_q;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  assert_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (shadow_o == pend_q));
endmodule

// File: rtl/i2c_trim_slave.sv
module i2c_trim_slave
  import trim_pkg::*;
#(
  parameter int         CODE_W   = 7,
  parameter logic [6:0] DEV_ADDR = 7'h4F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic              wp_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sda_oe_o,
  output logic              wr_o,
  output logic [CODE_W-1:0] wr_data_o
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  slv_state_e        state_q;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] sh_q, tx_q, tx_byte;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_ph_q, reg_ok_q, rd_q, mack_q, oe_q, wr_q;
  logic [CODE_W-1:0] wd_q;
  logic              scl_rise, scl_fall, start_c, stop_c, rx_st, byte_full;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_c   = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c    = scl_i & scl_q & ~sda_q & sda_i;
  assign rx_st     = (state_q == ST_ADDR) || (state_q == ST_REG) ||
                     (state_q == ST_DATA) || (state_q == ST_EXTRA);
  assign byte_full = (cnt_q == CNT_W'(BYTE_W));
  assign tx_byte   = BYTE_W'(code_i);  // upper bit(s) read as zero

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      sh_q     <= '0;
      tx_q     <= '0;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      reg_ok_q <= 1'b0;
      rd_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      wr_q  <= 1'b0;
      if (start_c) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_c) begin
        state_q  <= ST_IDLE;
        ack_ph_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (scl_rise) begin
        if (ack_ph_q) begin
          if (state_q == ST_TX_ACK) mack_q <= ~sda_i;
        end else if (rx_st) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end else if (state_q == ST_TX) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (scl_fall) begin
        if (ack_ph_q) begin
          // end of ninth bit: release and advance
          ack_ph_q <= 1'b0;
          oe_q     <= 1'b0;
          cnt_q    <= '0;
          case (state_q)
            ST_ADDR: begin
              if (rd_q) begin
                state_q <= ST_TX;
                tx_q    <= tx_byte;
                oe_q    <= ~tx_byte[BYTE_W-1];
              end else begin
                state_q <= ST_REG;
              end
            end
            ST_REG:            state_q <= ST_DATA;
            ST_DATA, ST_EXTRA: state_q <= ST_EXTRA;
            ST_TX_ACK: begin
              if (mack_q) begin
                state_q <= ST_TX;
                tx_q    <= tx_byte;
                oe_q    <= ~tx_byte[BYTE_W-1];
              end else begin
                state_q <= ST_IDLE;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end else if (rx_st && byte_full) begin
          ack_ph_q <= 1'b1;
          oe_q     <= 1'b1;
          case (state_q)
            ST_ADDR: begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR && !busy_i) begin
                rd_q <= sh_q[0];
              end else begin
                state_q  <= ST_IDLE;
                ack_ph_q <= 1'b0;
                oe_q     <= 1'b0;
              end
            end
            ST_REG:  reg_ok_q <= (sh_q == '0);
            ST_DATA: begin
              if (reg_ok_q && wp_i) begin
                wr_q <= 1'b1;
                wd_q <= sh_q[CODE_W-1:0];
              end
            end
            default: ;
          endcase
        end else if (state_q == ST_TX) begin
          if (byte_full) begin
            oe_q     <= 1'b0;
            state_q  <= ST_TX_ACK;
            ack_ph_q <= 1'b1;
          end else begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            oe_q <= ~tx_q[BYTE_W-2];
          end
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_o      = wr_q;
  assign wr_data_o = wd_q;

  assert_oe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q != ST_IDLE));
endmodule

// File: rtl/vcom_trim_i2c.sv
module vcom_trim_i2c #(
  parameter int                CODE_W     = 7,
  parameter logic [6:0]        DEV_ADDR   = 7'h4F,
  parameter int                FILT_LEN   = 8,
  parameter int                COMMIT_CYC = 12_500_000,
  parameter logic [CODE_W-1:0] INIT_CODE  = 7'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wp_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  localparam int NLINES = 2;  // [1]=SCL, [0]=SDA

  logic [NLINES-1:0] line_raw, line_flt;
  logic [1:0]        wp_sync_q;
  logic              wp_d_q, wp_s, wp_fall;
  logic              wr;
  logic [CODE_W-1:0] wd, shadow, code_q;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (line_raw[g]),
      .out_o  (line_flt[g])
    );
  end

  // write enable defaults to protected (low) out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_sync_q <= 2'b00;
      wp_d_q    <= 1'b0;
    end else begin
      wp_sync_q <= {wp_sync_q[0], wp_i};
      wp_d_q    <= wp_sync_q[1];
    end
  end
  assign wp_s    = wp_sync_q[1];
  assign wp_fall = wp_d_q & ~wp_s;

  i2c_trim_slave #(.CODE_W(CODE_W), .DEV_ADDR(DEV_ADDR)) u_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (line_flt[1]),
    .sda_i     (line_flt[0]),
    .busy_i    (busy_o),
    .wp_i      (wp_s),
    .code_i    (code_q),
    .sda_oe_o  (sda_oe_o),
    .wr_o      (wr),
    .wr_data_o (wd)
  );

  nv_shadow #(.CODE_W(CODE_W), .COMMIT_CYC(COMMIT_CYC), .INIT_CODE(INIT_CODE)) u_nv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr),
    .data_i   (wd),
    .shadow_o (shadow),
    .busy_o   (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= INIT_CODE;
    else if (wp_fall) code_q <= shadow;
    else if (wr)      code_q <= wd;
  end
  assign code_o = code_q;

  assert_code_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> ($past(wr) || $past(wp_fall)));

  assert_wp_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_fall |=> (code_q == $past(shadow)));

  assert_wr_wp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr) |-> $past(wp_s));
endmodule

// File: tb/vcom_trim_i2c_tb.sv
module vcom_trim_i2c_tb;
  localparam int         Q      = 32;
  localparam int         CYC    = 3000;
  localparam logic [6:0] INIT   = 7'h2A;
  localparam int         NVEC   = 6;
  // {wp, reg byte, data byte, expected code}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01_00_15_15, 32'h01_00_7F_7F, 32'h01_00_80_00,
    32'h00_00_33_00, 32'h01_05_44_00, 32'h01_00_01_01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp_m = 1'b0;
  logic sda_oe, busy;
  logic [6:0] code;
  logic sda_w;
  int checks = 0, failures = 0;
  int busy_cnt = 0;
  logic busy_clr = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sda_w = sda_m & ~sda_oe;

  vcom_trim_i2c #(.COMMIT_CYC(CYC), .INIT_CODE(INIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .wp_i(wp_m), .code_o(code), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (busy_clr) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    if (glitch) begin
      sda_m = b; tick(8);
      scl_m = 1'b1; tick(5); scl_m = 1'b0;   // short SCL spike
      tick(Q - 13);
      scl_m = 1'b1; tick(Q);
      sda_m = ~b; tick(5); sda_m = b;        // short SDA spike
      tick(Q - 5);
      scl_m = 1'b0; tick(Q);
    end else begin
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_w;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_w;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    send_bit(~mack, 1'b0);
  endtask

  task automatic wr_txn(input logic [7:0] rb, input logic [7:0] db, input logic glitch,
                        output logic [2:0] acks);
    logic a;
    i2c_start;
    send_byte(8'h9E, 1'b0, a); acks[2] = a;
    send_byte(rb, glitch, a);  acks[1] = a;
    send_byte(db, glitch, a);  acks[0] = a;
    i2c_stop;
  endtask

  task automatic rd_txn(output logic aack, output logic [7:0] b);
    i2c_start;
    send_byte(8'h9F, 1'b0, aack);
    if (aack) recv_byte(1'b0, b);
    else b = 8'hFF;
    i2c_stop;
  endtask

  task automatic wait_idle;
    while (busy) tick(1);
    tick(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic a;
    logic [7:0] rb;
    tick(5);
    // R1 reset state, held in reset and after release
    check(code == INIT && !busy && !sda_oe, "R1 in reset", {busy, sda_oe, code}, INIT);
    rst_n = 1'b1;
    tick(20);
    check(code == INIT && !busy && !sda_oe, "R1 after reset", {busy, sda_oe, code}, INIT);
    rd_txn(a, rb);
    check(a && rb == {1'b0, INIT}, "R8 read initial", rb, {1'b0, INIT});

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      e = VEC[v];
      wp_m = e[24];
      tick(10);
      busy_clr = 1'b1; tick(1); busy_clr = 1'b0;
      wr_txn(e[23:16], e[15:8], 1'b0, acks);
      check(acks == 3'b111, "R2/R3/R9 write acks", acks, 7);
      wait_idle;
      check(code == e[6:0], "R3/R4/R9 code after write", code, e[6:0]);
      if (e[24] && e[23:16] == 8'h00)
        check(busy_cnt == CYC, "R6 busy length", busy_cnt, CYC);
      else
        check(busy_cnt == 0, "R4/R9 no commit", busy_cnt, 0);
      rd_txn(a, rb);
      check(a && rb == {1'b0, e[6:0]}, "R8 read back", rb, {1'b0, e[6:0]});
      check(!sda_oe, "R8 released after stop", sda_oe, 0);
    end

    // R2 foreign address
    i2c_start;
    send_byte(8'h90, 1'b0, a);
    check(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h00, 1'b0, a);
    check(!a && !sda_oe, "R2 stays off bus", {a, sda_oe}, 0);
    i2c_stop;

    // R7 busy nack; R6 commit of 0x11
    wp_m = 1'b1; tick(10);
    wr_txn(8'h00, 8'h11, 1'b0, acks);
    check(busy, "R6 busy after write", busy, 1);
    i2c_start;
    send_byte(8'h9E, 1'b0, a);
    i2c_stop;
    check(!a, "R7 write address nack while busy", a, 0);
    rd_txn(a, rb);
    check(!a, "R7 read address nack while busy", a, 0);
    wait_idle;
    check(code == 7'h11, "R3 code 0x11", code, 7'h11);

    // R5 reload during a running commit returns last completed value
    wr_txn(8'h00, 8'h22, 1'b0, acks);
    check(code == 7'h22 && busy, "R3 live code during commit", code, 7'h22);
    wp_m = 1'b0; tick(10);
    check(code == 7'h11, "R5 reload during commit", code, 7'h11);
    wait_idle;
    check(code == 7'h11, "R5 code held after commit", code, 7'h11);
    wp_m = 1'b1; tick(10);
    wp_m = 1'b0; tick(10);
    check(code == 7'h22, "R5 reload after commit", code, 7'h22);

    // R9 extra bytes after the data byte
    wp_m = 1'b1; tick(10);
    i2c_start;
    send_byte(8'h9E, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h05, 1'b0, a);
    send_byte(8'h66, 1'b0, a);
    check(a, "R9 extra byte ack", a, 1);
    i2c_stop;
    wait_idle;
    check(code == 7'h05, "R9 extra byte ignored", code, 7'h05);

    // R10 spikes on both lines during a write
    wr_txn(8'h00, 8'h5A, 1'b1, acks);
    check(acks == 3'b111, "R10 acks with spikes", acks, 7);
    wait_idle;
    check(code == 7'h5A, "R10 code with spikes", code, 7'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule